// File: doc/BRIEF.md
# Serial-Access Shift/Storage Register Pair

This block pairs a 16-bit shift register with a 16-bit storage register and joins them in both directions. Data enters and leaves the shift register one bit at a time through a single bidirectional serial pin. That pin is modelled as an input value plus an output-data/output-enable pair. The storage register can take a parallel snapshot of the shift register, and its outputs then show the shifted data. It can also push its own contents back into the shift register in one step.

A chip-disable input freezes both registers and releases the serial pin. The storage register also has an active-low clear that acts asynchronously. This clear still works while the chip is disabled. The two clocks of the block are modelled as one-cycle strobes sampled on a single system clock. Because of this, a chip-disable transition can never produce a stray clock edge. The final shift stage is also brought out directly as a serial tap.

Top module: `sreg_pair`

## Requirements
- R1: After synchronous reset (`rst` high), the shift register and the storage register both read zero, `sdata_oe` is 0 and `tail_q` is 0.
- R2: With `chip_disable`=0 and `read_mode`=0 (write), each `shift_stb` moves the shift register one place toward bit 15 and loads `sdata_in` into bit 0, so 16 strobes fed MSB first leave that word in the shift register; `tail_q` always shows bit 15.
- R3: With `chip_disable`=0 and `read_mode`=1 (read), `sdata_oe` is 1 and `sdata_out` equals shift bit 15; each `shift_stb` moves bit 15 into bit 0, so after 16 read strobes the contents are unchanged.
- R4: A `store_stb` with `xfer_sel`=0 copies all 16 shift bits into the storage register, which drives `par_q`.
- R5: A `store_stb` with `xfer_sel`=1 copies all 16 storage bits into the shift register and leaves the storage register unchanged.
- R6: While `chip_disable`=1, `shift_stb` and `store_stb` have no effect on either register, and `sdata_oe` is 0.
- R7: While `clear_n` is low, `par_q` is zero at once, with no clock edge needed, and this holds even with `chip_disable`=1.
- R8: A `store_stb` with `xfer_sel`=1 while `clear_n` is low loads zeros into the shift register.
- R9: When `shift_stb` and a `store_stb` with `xfer_sel`=1 occur in the same cycle, the parallel load wins and the shift is dropped.
- R10: When `shift_stb` and a `store_stb` with `xfer_sel`=0 occur in the same cycle, the storage register captures the shift contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_disable | input | 1 | High freezes both registers and releases the serial pin |
| shift_stb | input | 1 | One-cycle shift-clock strobe |
| store_stb | input | 1 | One-cycle storage-clock strobe |
| read_mode | input | 1 | 1 = read (drive pin, recirculate), 0 = write (take pin) |
| xfer_sel | input | 1 | Storage-strobe action: 0 shift→storage, 1 storage→shift |
| clear_n | input | 1 | Asynchronous active-low storage clear |
| sdata_in | input | 1 | Value seen on the serial pin |
| sdata_out | output | 1 | Value driven onto the serial pin |
| sdata_oe | output | 1 | Serial pin output enable |
| par_q | output | 16 | Storage register parallel outputs |
| tail_q | output | 1 | Shift register bit 15 tap |

## Verification
A table of words is written serially, captured, and then read back serially and captured again. The words are alternating, single-low-bit, single-high-bit, all-ones, all-zeros and mixed. A single set bit at either end exposes a wrong shift direction or a wrong end for serial entry. All-ones and all-zeros expose stuck bits. The read-back exposes a recirculation that loses or duplicates bits. Further directed cases cover the following:
- A reload from storage, which must differ from the current shift contents.
- Strobes while disabled.
- A clear while disabled.
- A reload during clear.
- Coincident strobe pairs, which tell the priority apart from a merge of the two actions.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic {
        XFER_TO_STORE = 1'b0,
        XFER_TO_SHIFT = 1'b1
    } xfer_e;

    typedef struct packed {
        logic shift_go;
        logic capture_go;
        logic reload_go;
        logic recirc;
    } sreg_ctl_t;

    function automatic logic pin_enable(input logic dis, input logic rd, input logic rst);
        return !dis && rd && !rst;
    endfunction

endpackage

// File: rtl/sreg_ctl.sv
module sreg_ctl
    import sreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      chip_disable,
    input  logic      shift_stb,
    input  logic      store_stb,
    input  logic      read_mode,
    input  logic      xfer_sel,
    output sreg_ctl_t ctl,
    output logic      pin_oe
);
    xfer_e dir;

    always_comb begin
        dir            = xfer_e'(xfer_sel);
        ctl.shift_go   = !chip_disable && shift_stb;
        ctl.capture_go = !chip_disable && store_stb && (dir == XFER_TO_STORE);
        ctl.reload_go  = !chip_disable && store_stb && (dir == XFER_TO_SHIFT);
        ctl.recirc     = read_mode;
        pin_oe         = pin_enable(chip_disable, read_mode, rst);
    end

    // R6
    gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        chip_disable |-> !(ctl.shift_go || ctl.capture_go || ctl.reload_go || pin_oe));

endmodule

// File: rtl/sreg_shift.sv
module sreg_shift
    import sreg_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sreg_ctl_t        ctl,
    input  logic             sdin,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    logic entry_bit;
    assign entry_bit = ctl.recirc ? q[TOP] : sdin;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ctl.reload_go)
            q <= load_val;
        else if (ctl.shift_go)
            q <= {q[TOP-1:0], entry_bit};
    end

    // R3
    recirc_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift_go && !ctl.reload_go && ctl.recirc) |=> q == {$past(q[TOP-1:0]), $past(q[TOP])});

    // R9
    reload_first_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.reload_go |=> q == $past(load_val));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.shift_go || ctl.reload_go) |=> $stable(q));

endmodule

// File: rtl/sreg_store.sv
module sreg_store #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            q <= '0;
        else if (rst)
            q <= '0;
        else if (capture)
            q <= d;
    end

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> q == '0);

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && clear_n) |=> (q == $past(d) || !clear_n));

endmodule

// File: rtl/sreg_pair.sv
module sreg_pair
    import sreg_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_disable,
    input  logic             shift_stb,
    input  logic             store_stb,
    input  logic             read_mode,
    input  logic             xfer_sel,
    input  logic             clear_n,
    input  logic             sdata_in,
    output logic             sdata_out,
    output logic             sdata_oe,
    output logic [WIDTH-1:0] par_q,
    output logic             tail_q
);
    localparam int TOP = WIDTH - 1;

    sreg_ctl_t        ctl;
    logic             pin_oe;
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] store_q;

    sreg_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .chip_disable (chip_disable),
        .shift_stb    (shift_stb),
        .store_stb    (store_stb),
        .read_mode    (read_mode),
        .xfer_sel     (xfer_sel),
        .ctl          (ctl),
        .pin_oe       (pin_oe)
    );

    sreg_shift #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .sdin     (sdata_in),
        .load_val (store_q),
        .q        (shift_q)
    );

    sreg_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .capture (ctl.capture_go),
        .d       (shift_q),
        .q       (store_q)
    );

    assign sdata_oe  = pin_oe;
    assign sdata_out = pin_oe ? shift_q[TOP] : 1'b0;
    assign par_q     = store_q;
    assign tail_q    = shift_q[TOP];

    // R8
    clear_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (store_stb && xfer_sel && !chip_disable && !clear_n) |=> shift_q == '0);

    // R10
    pre_shift_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_stb && store_stb && !xfer_sel && !chip_disable && clear_n)
            |=> (par_q == $past(shift_q) || !clear_n));

    // R3
    pin_drive_chk: assert property (@(posedge clk) disable iff (rst)
        sdata_oe |-> sdata_out == tail_q);

endmodule

// File: tb/sreg_pair_test.sv
module sreg_pair_test;
    localparam int W = 16;
    localparam int NVEC = 6;
    localparam logic [W-1:0] VEC_IN  [NVEC] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 16'h1234};
    localparam int           VEC_ONES[NVEC] = '{8, 1, 1, 16, 0, 5};

    logic clk = 0;
    logic rst, chip_disable, shift_stb, store_stb, read_mode, xfer_sel, clear_n, sdata_in;
    logic sdata_out, sdata_oe, tail_q;
    logic [W-1:0] par_q;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    sreg_pair #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .chip_disable(chip_disable), .shift_stb(shift_stb),
        .store_stb(store_stb), .read_mode(read_mode), .xfer_sel(xfer_sel),
        .clear_n(clear_n), .sdata_in(sdata_in), .sdata_out(sdata_out),
        .sdata_oe(sdata_oe), .par_q(par_q), .tail_q(tail_q)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        shift_stb = 0; store_stb = 0;
    endtask

    task automatic write_word(input logic [W-1:0] w);
        read_mode = 0;
        for (int i = W - 1; i >= 0; i--) begin
            sdata_in = w[i]; shift_stb = 1;
            step();
        end
    endtask

    task automatic read_word(output logic [W-1:0] v);
        read_mode = 1; #1;
        v = '0;
        for (int i = 0; i < W; i++) begin
            v = {v[W-2:0], sdata_out};
            shift_stb = 1;
            step();
            #1;
        end
    endtask

    task automatic store(input logic dir);
        xfer_sel = dir; store_stb = 1;
        step();
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;
        rst = 1; chip_disable = 0; shift_stb = 0; store_stb = 0; read_mode = 0;
        xfer_sel = 0; clear_n = 1; sdata_in = 0;
        repeat (3) @(negedge clk);
        chk("R1 par_q", par_q, '0);
        chk("R1 oe", {15'b0, sdata_oe}, '0);
        chk("R1 tail", {15'b0, tail_q}, '0);
        rst = 0;
        @(negedge clk);
        read_word(rd);
        chk("R1 shift zero", rd, '0);

        for (int k = 0; k < NVEC; k++) begin
            write_word(VEC_IN[k]);
            chk("R2 tail", {15'b0, tail_q}, {15'b0, VEC_IN[k][W-1]});
            store(1'b0);
            chk("R4 capture", par_q, VEC_IN[k]);
            chk("R4 ones", $countones(par_q), VEC_ONES[k]);
            read_mode = 1; #1;
            chk("R3 oe", {15'b0, sdata_oe}, 16'd1);
            read_word(rd);
            chk("R3 serial out", rd, VEC_IN[k]);
            store(1'b0);
            chk("R3 recirculated", par_q, VEC_IN[k]);
        end

        // R5: reload from storage (holds 1234)
        write_word(16'h0F0F);
        store(1'b1);
        chk("R5 storage kept", par_q, 16'h1234);
        read_word(rd);
        chk("R5 reload", rd, 16'h1234);

        // R6: strobes while disabled
        chip_disable = 1; read_mode = 1; #1;
        chk("R6 oe off", {15'b0, sdata_oe}, '0);
        write_word(16'hFFFF);
        store(1'b0);
        store(1'b1);
        chk("R6 storage held", par_q, 16'h1234);
        chip_disable = 0;
        read_word(rd);
        chk("R6 shift held", rd, 16'h1234);

        // R7: clear acts at once while disabled
        chip_disable = 1;
        #2 clear_n = 0; #1;
        chk("R7 async clear", par_q, '0);
        @(negedge clk);
        chip_disable = 0;
        // R8: reload during clear gives zeros
        store(1'b1);
        read_word(rd);
        chk("R8 reload zeros", rd, '0);
        clear_n = 1;
        @(negedge clk);

        // R9: load beats shift
        write_word(16'h00FF);
        store(1'b0);
        write_word(16'h3C00);
        read_mode = 0; sdata_in = 1; shift_stb = 1;
        store(1'b1);
        read_word(rd);
        chk("R9 load wins", rd, 16'h00FF);

        // R10: capture sees pre-shift value
        write_word(16'h8421);
        read_mode = 0; sdata_in = 1; shift_stb = 1;
        store(1'b0);
        chk("R10 pre-shift capture", par_q, 16'h8421);
        read_word(rd);
        chk("R10 shift applied", rd, 16'h0843);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule